// File: doc/BRIEF.md
# Host/Ingress Dispatch Router

The router takes frame handles from two sources, a host-return path and an Ethernet ingress path. It sends each handle to one of three destinations: egress, the host exception path or a drop sink. A frame that comes back from the host has strict priority and goes straight to egress. An ingress frame is checked first for its validity flag. An invalid frame is discarded. A valid frame is offered to an external classifier, and the classifier's return code decides whether the frame goes to the host or to egress.

The router handles one frame at a time. It holds a frame until its destination accepts it, and it takes no new frame while a frame is in flight or while it waits for the classifier. A running count of frames delivered to the host can be read with a one-cycle request/response query.

Top module: `dispatch_router`

## Requirements
- R1: After reset, no output valid is asserted, both sources are offered ready, and a counter query returns 0.
- R2: When the router is idle and both sources present a frame, only the host-return source gets ready. The ingress ready stays low in that cycle.
- R3: A host-return frame is sent to egress with its handle unchanged, and no classifier request is raised for it.
- R4: An ingress frame whose validity flag is 0 is sent to the drop sink with its handle unchanged, and no classifier request is raised for it.
- R5: A valid ingress frame raises a classifier request carrying its handle. A response code of 0 sends the frame to the host exception path.
- R6: A valid ingress frame whose classifier response code is nonzero is sent to egress.
- R7: Once presented, a destination's valid and handle stay stable until that destination asserts ready.
- R8: At most one of the egress, host, drop and classifier-request valids is high at a time. While any of them is high, neither source is offered ready.
- R9: The host counter is CNT_W bits wide (32 by default). It rises by exactly one for each frame the host path accepts, and it does not change otherwise.
- R10: A query pulse in one cycle gives a response valid in the next cycle. The response carries the counter value held before any increment in the query cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hr_valid | input | 1 | Host-return frame present |
| hr_handle | input | HW | Host-return frame handle |
| hr_ready | output | 1 | Host-return frame taken |
| ig_valid | input | 1 | Ingress frame present |
| ig_handle | input | HW | Ingress frame handle |
| ig_ok | input | 1 | Ingress validity flag (1 = valid) |
| ig_ready | output | 1 | Ingress frame taken |
| cls_req_valid | output | 1 | Classifier request pending |
| cls_req_handle | output | HW | Handle under classification |
| cls_rsp_valid | input | 1 | Classifier response present |
| cls_rsp_code | input | CW | Classifier return code (0 = to host) |
| eg_valid | output | 1 | Egress frame valid |
| eg_handle | output | HW | Egress frame handle |
| eg_ready | input | 1 | Egress accepts |
| xh_valid | output | 1 | Host exception frame valid |
| xh_handle | output | HW | Host exception frame handle |
| xh_ready | input | 1 | Host path accepts |
| dr_valid | output | 1 | Drop sink frame valid |
| dr_handle | output | HW | Drop sink frame handle |
| dr_ready | input | 1 | Drop sink accepts |
| cnt_rd_req | input | 1 | Counter query pulse |
| cnt_rd_valid | output | 1 | Counter query response valid |
| cnt_rd_data | output | CNT_W | Counter query response value |

## Verification
The hardest case to reach is a counter query in the very cycle the host path accepts a frame. That cycle needs a frame classified with code 0, sitting on the host output, and a ready from the host path, all lined up with the query pulse. The bench gets there with long random runs that use a high query rate and several ready and response rates, so that many such coincidences occur. A reference model compares every cycle, and the returned value must be the pre-increment count. Host-return and ingress frames are also made to arrive together often, and frames are held back under backpressure, to exercise the priority and hold rules.

// File: rtl/dispatch_router.sv
module dispatch_router #(
  parameter int HW    = 16,
  parameter int CW    = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hr_valid,
  input  logic [HW-1:0]    hr_handle,
  output logic             hr_ready,
  input  logic             ig_valid,
  input  logic [HW-1:0]    ig_handle,
  input  logic             ig_ok,
  output logic             ig_ready,
  output logic             cls_req_valid,
  output logic [HW-1:0]    cls_req_handle,
  input  logic             cls_rsp_valid,
  input  logic [CW-1:0]    cls_rsp_code,
  output logic             eg_valid,
  output logic [HW-1:0]    eg_handle,
  input  logic             eg_ready,
  output logic             xh_valid,
  output logic [HW-1:0]    xh_handle,
  input  logic             xh_ready,
  output logic             dr_valid,
  output logic [HW-1:0]    dr_handle,
  input  logic             dr_ready,
  input  logic             cnt_rd_req,
  output logic             cnt_rd_valid,
  output logic [CNT_W-1:0] cnt_rd_data
);

  typedef enum logic [1:0] {S_IDLE, S_CLS, S_OUT} state_t;
  typedef enum logic [1:0] {D_EG, D_HOST, D_DROP} dest_t;

  state_t           state_q;
  dest_t            dest_q;
  logic [HW-1:0]    hdl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_v_q;
  logic [CNT_W-1:0] rd_d_q;

  logic idle, presenting, out_taken, host_taken;

  assign idle       = (state_q == S_IDLE);
  assign presenting = (state_q == S_OUT);

  assign hr_ready = idle;
  assign ig_ready = idle & ~hr_valid;

  assign cls_req_valid  = (state_q == S_CLS);
  assign cls_req_handle = hdl_q;

  assign eg_valid  = presenting & (dest_q == D_EG);
  assign xh_valid  = presenting & (dest_q == D_HOST);
  assign dr_valid  = presenting & (dest_q == D_DROP);
  assign eg_handle = hdl_q;
  assign xh_handle = hdl_q;
  assign dr_handle = hdl_q;

  assign host_taken = xh_valid & xh_ready;
  assign out_taken  = (eg_valid & eg_ready) | host_taken | (dr_valid & dr_ready);

  assign cnt_rd_valid = rd_v_q;
  assign cnt_rd_data  = rd_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dest_q  <= D_EG;
      hdl_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (hr_valid) begin
            hdl_q   <= hr_handle;
            dest_q  <= D_EG;
            state_q <= S_OUT;
          end else if (ig_valid) begin
            hdl_q <= ig_handle;
            if (ig_ok) begin
              state_q <= S_CLS;
            end else begin
              dest_q  <= D_DROP;
              state_q <= S_OUT;
            end
          end
        end
        S_CLS: begin
          if (cls_rsp_valid) begin
            dest_q  <= (cls_rsp_code == '0) ? D_HOST : D_EG;
            state_q <= S_OUT;
          end
        end
        S_OUT: begin
          if (out_taken) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rd_v_q <= 1'b0;
      rd_d_q <= '0;
    end else begin
      if (host_taken) cnt_q <= cnt_q + 1'b1;
      rd_v_q <= cnt_rd_req;
      if (cnt_rd_req) rd_d_q <= cnt_q;
    end
  end

endmodule

// File: rtl/dispatch_router_chk.sv
module dispatch_router_chk #(
  parameter int HW    = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hr_valid,
  input logic [HW-1:0]    hr_handle,
  input logic             hr_ready,
  input logic             ig_valid,
  input logic [HW-1:0]    ig_handle,
  input logic             ig_ok,
  input logic             ig_ready,
  input logic             cls_req_valid,
  input logic             eg_valid,
  input logic [HW-1:0]    eg_handle,
  input logic             eg_ready,
  input logic             xh_valid,
  input logic             xh_ready,
  input logic             dr_valid,
  input logic [HW-1:0]    dr_handle,
  input logic             dr_ready,
  input logic             cnt_rd_req,
  input logic             cnt_rd_valid,
  input logic [CNT_W-1:0] cnt_rd_data,
  input logic [CNT_W-1:0] cnt
);

  AST_HR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hr_valid |-> !ig_ready); // R2

  AST_HR_TO_EG: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_valid && hr_ready) |=> (eg_valid && eg_handle == $past(hr_handle) && !cls_req_valid)); // R3

  AST_BAD_TO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ig_valid && ig_ready && !ig_ok) |=> (dr_valid && dr_handle == $past(ig_handle) && !cls_req_valid)); // R4

  AST_EG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_valid && !eg_ready) |=> (eg_valid && $stable(eg_handle))); // R7

  AST_DR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_handle))); // R7

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eg_valid, xh_valid, dr_valid, cls_req_valid})); // R8

  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (eg_valid || xh_valid || dr_valid || cls_req_valid) |-> (!hr_ready && !ig_ready)); // R8

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (xh_valid && xh_ready) |=> (cnt == $past(cnt) + 1'b1)); // R9

  AST_CNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(xh_valid && xh_ready) |=> $stable(cnt)); // R9

  AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_req |=> (cnt_rd_valid && cnt_rd_data == $past(cnt))); // R10

endmodule

bind dispatch_router dispatch_router_chk #(.HW(HW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .hr_valid(hr_valid), .hr_handle(hr_handle), .hr_ready(hr_ready),
  .ig_valid(ig_valid), .ig_handle(ig_handle), .ig_ok(ig_ok), .ig_ready(ig_ready),
  .cls_req_valid(cls_req_valid),
  .eg_valid(eg_valid), .eg_handle(eg_handle), .eg_ready(eg_ready),
  .xh_valid(xh_valid), .xh_ready(xh_ready),
  .dr_valid(dr_valid), .dr_handle(dr_handle), .dr_ready(dr_ready),
  .cnt_rd_req(cnt_rd_req), .cnt_rd_valid(cnt_rd_valid), .cnt_rd_data(cnt_rd_data),
  .cnt(cnt_q)
);

// File: tb/dispatch_router_tb_top.sv
`timescale 1ns/1ps
module dispatch_router_tb_top;
  localparam int HW = 16;
  localparam int CW = 8;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic hr_valid = 0, ig_valid = 0, ig_ok = 0, cls_rsp_valid = 0;
  logic eg_ready = 0, xh_ready = 0, dr_ready = 0, cnt_rd_req = 0;
  logic [HW-1:0] hr_handle = '0, ig_handle = '0;
  logic [CW-1:0] cls_rsp_code = '0;
  logic hr_ready, ig_ready, cls_req_valid, eg_valid, xh_valid, dr_valid, cnt_rd_valid;
  logic [HW-1:0] cls_req_handle, eg_handle, xh_handle, dr_handle;
  logic [CNT_W-1:0] cnt_rd_data;

  dispatch_router #(.HW(HW), .CW(CW), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .hr_valid(hr_valid), .hr_handle(hr_handle), .hr_ready(hr_ready),
    .ig_valid(ig_valid), .ig_handle(ig_handle), .ig_ok(ig_ok), .ig_ready(ig_ready),
    .cls_req_valid(cls_req_valid), .cls_req_handle(cls_req_handle),
    .cls_rsp_valid(cls_rsp_valid), .cls_rsp_code(cls_rsp_code),
    .eg_valid(eg_valid), .eg_handle(eg_handle), .eg_ready(eg_ready),
    .xh_valid(xh_valid), .xh_handle(xh_handle), .xh_ready(xh_ready),
    .dr_valid(dr_valid), .dr_handle(dr_handle), .dr_ready(dr_ready),
    .cnt_rd_req(cnt_rd_req), .cnt_rd_valid(cnt_rd_valid), .cnt_rd_data(cnt_rd_data)
  );

  int total = 0, bad = 0;

  // Reference model: busy = 0 free, 1 awaiting classifier, 2 holding frame
  int busy = 0;
  int where = 0;           // 0 egress, 1 host, 2 drop
  int held = 0;
  longint hosted = 0;
  bit rd_pend = 0;
  longint rd_val = 0;
  int host_events = 0, rd_on_host = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0; where = 0; held = 0; hosted = 0; rd_pend = 0; rd_val = 0;
    end else begin
      rd_pend = cnt_rd_req;
      if (cnt_rd_req) rd_val = hosted;
      if (busy == 2 && where == 1 && xh_ready) begin
        if (cnt_rd_req) rd_on_host++;
        hosted = (hosted + 1) % (64'd1 << CNT_W);
        host_events++;
      end
      if (busy == 0) begin
        if (hr_valid) begin held = hr_handle; where = 0; busy = 2; end
        else if (ig_valid) begin
          held = ig_handle;
          if (ig_ok) busy = 1; else begin where = 2; busy = 2; end
        end
      end else if (busy == 1) begin
        if (cls_rsp_valid) begin where = (cls_rsp_code == 0) ? 1 : 0; busy = 2; end
      end else begin
        if ((where == 0 && eg_ready) || (where == 1 && xh_ready) || (where == 2 && dr_ready))
          busy = 0;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "hr_ready", hr_ready, busy == 0);
    chk("R8", "ig_ready", ig_ready, busy == 0 && !hr_valid);
    chk("R5", "cls_req_valid", cls_req_valid, busy == 1);
    if (busy == 1) chk("R5", "cls_req_handle", cls_req_handle, held);
    chk("R3", "eg_valid", eg_valid, busy == 2 && where == 0);
    chk("R5", "xh_valid", xh_valid, busy == 2 && where == 1);
    chk("R4", "dr_valid", dr_valid, busy == 2 && where == 2);
    if (busy == 2 && where == 0) chk("R6", "eg_handle", eg_handle, held);
    if (busy == 2 && where == 1) chk("R7", "xh_handle", xh_handle, held);
    if (busy == 2 && where == 2) chk("R4", "dr_handle", dr_handle, held);
    chk("R10", "cnt_rd_valid", cnt_rd_valid, rd_pend);
    if (rd_pend) chk("R9", "cnt_rd_data", cnt_rd_data, rd_val);
  endtask

  bit timed_out = 0;
  initial begin
    int cyc = 0;
    while (cyc < 150000 && !timed_out) begin @(posedge clk); cyc++; end
    if (!timed_out && cyc >= 150000) timed_out = 1;
  end

  initial begin
    bit hold_hr = 0, hold_ig = 0;
    int p_hr, p_ig, p_bad, p_rsp, p_rdy, p_rd;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R1", "eg_valid in reset", eg_valid, 0);
      chk("R1", "xh_valid in reset", xh_valid, 0);
      chk("R1", "dr_valid in reset", dr_valid, 0);
      chk("R1", "cls_req_valid in reset", cls_req_valid, 0);
    end
    @(negedge clk);
    rst_n = 1; cnt_rd_req = 1;
    #1;
    chk("R1", "hr_ready after reset", hr_ready, 1);
    chk("R1", "ig_ready after reset", ig_ready, 1);
    @(negedge clk);
    cnt_rd_req = 0;
    #1;
    chk("R1", "cnt_rd_valid after reset", cnt_rd_valid, 1);
    chk("R1", "cnt_rd_data after reset", cnt_rd_data, 0);
    for (int ph = 0; ph < 3 && !timed_out; ph++) begin
      case (ph)
        0: begin p_hr = 50; p_ig = 70; p_bad = 20; p_rsp = 60; p_rdy = 60; p_rd = 40; end
        1: begin p_hr = 10; p_ig = 90; p_bad = 40; p_rsp = 90; p_rdy = 90; p_rd = 70; end
        default: begin p_hr = 30; p_ig = 80; p_bad = 10; p_rsp = 30; p_rdy = 25; p_rd = 50; end
      endcase
      for (int c = 0; c < 4000 && !timed_out; c++) begin
        @(negedge clk);
        if (!hold_hr) begin
          hr_valid = ($urandom_range(99) < p_hr);
          hr_handle = HW'($urandom);
        end
        if (!hold_ig) begin
          ig_valid = ($urandom_range(99) < p_ig);
          ig_handle = HW'($urandom);
          ig_ok = !($urandom_range(99) < p_bad);
        end
        cls_rsp_valid = ($urandom_range(99) < p_rsp);
        cls_rsp_code = ($urandom_range(1) == 0) ? '0 : CW'($urandom_range(255, 1));
        eg_ready = ($urandom_range(99) < p_rdy);
        xh_ready = ($urandom_range(99) < p_rdy);
        dr_ready = ($urandom_range(99) < p_rdy);
        cnt_rd_req = ($urandom_range(99) < p_rd);
        #1;
        compare_all();
        hold_hr = hr_valid && !hr_ready;
        hold_ig = ig_valid && !ig_ready;
      end
    end
    @(negedge clk);
    hr_valid = 0; ig_valid = 0; cnt_rd_req = 0;
    chk("R9", "host deliveries seen", host_events > 20, 1);
    chk("R10", "query during host delivery seen", rd_on_host > 0, 1);
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule